// File: doc/BRIEF.md
# Energy-Operator Spike Detector with Lockout

This block takes a stream of already band-limited signed samples, each marked by a one-cycle valid strobe, and decides for every sample whether a neural spike has occurred. For each sample it forms a nonlinear energy value from the current sample and the two before it. It compares that energy against a threshold that adapts to the noise floor. The noise floor is followed by an exponentially weighted running average of the sample magnitude, and the threshold is a programmable gain times the square of that average.

When a sample's energy is strictly above the threshold, the block raises a one-clock spike pulse. At the same time it presents a 7-bit sample index that wraps around. It then locks out further detections for a programmable number of samples, so one spike waveform cannot fire more than once. The gain and the lockout length come from a neighbouring configuration block as write strobes with data. Both have reset defaults, so the detector works without any configuration.

Top module: `neo_spike_det`

## Requirements
- R1: After reset `spike` is 0, `timestamp` is 0, the sample history and noise average are 0, the sample index is 0, no lockout is active, the gain is 5 and the lockout length is 50.
- R2: For each accepted sample x[n] the energy is e = x[n-1]*x[n-1] - x[n]*x[n-2], using signed arithmetic that cannot overflow. A zero or negative e never produces a detection.
- R3: The noise average s holds 4 fractional bits and is updated once per accepted sample as s <- s + floor(((|x|<<4) - s) / 16), where |-128| = 128. The value s has no effect on the sample that updates it.
- R4: The threshold for a sample is k * m * m, where m = floor(s/16) is taken from s before that sample's update and k is the current gain. A detection requires e > threshold, with strict inequality.
- R5: A detection caused by the sample accepted at clock edge t shows up as `spike` = 1 for exactly the cycle after edge t. `spike` is 0 in every other cycle.
- R6: The sample index starts at 0, counts accepted samples and wraps from 127 to 0. When a spike fires, `timestamp` shows the index of the detecting sample, so the first sample after reset has index 0. `timestamp` keeps its value until the next spike.
- R7: After a detection with lockout length L, the next L accepted samples cannot be detected, whatever their energy. Sample L+1 after the detection is eligible again. With L = 0 there is no lockout.
- R8: A high `cfg_k_we` or `cfg_refr_we` at a clock edge loads `cfg_k_val` or `cfg_refr_val`. The new value applies to samples accepted at later edges. A lockout already running keeps its own length.
- R9: At an edge where `in_valid` is low, the sample history, noise average, sample index and lockout count do not change, and no spike fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a new filtered sample on `in_sample` |
| in_sample | input | 8 | Signed filtered sample, two's complement |
| cfg_k_we | input | 1 | Loads the threshold gain |
| cfg_k_val | input | 8 | New threshold gain (unsigned) |
| cfg_refr_we | input | 1 | Loads the lockout length |
| cfg_refr_val | input | 8 | New lockout length in samples (unsigned) |
| spike | output | 1 | One-cycle detection pulse |
| timestamp | output | 7 | Sample index of the most recent detection |

## Verification
The assertions assume that every input is a known value at each clock edge and that `in_valid` marks single samples. They also assume that configuration writes come from a block that drives them synchronously. The bench drives every input only on the falling edge, so each value is settled well before the rising edge that captures it. It issues configuration writes in cycles without a sample, which keeps the point at which a new gain or lockout length applies unambiguous. Sample values cover the full signed range, including -128 and 127. This exercises the widest products and the largest noise average the assertions bound.

// File: rtl/neo_spike_det.sv
module neo_spike_det #(
  parameter int DW       = 8,
  parameter int TSW      = 7,
  parameter int KW       = 8,
  parameter int RW       = 8,
  parameter int FRAC     = 4,
  parameter int SHIFT    = 4,
  parameter int K_DEF    = 5,
  parameter int REFR_DEF = 50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic                 cfg_k_we,
  input  logic [KW-1:0]        cfg_k_val,
  input  logic                 cfg_refr_we,
  input  logic [RW-1:0]        cfg_refr_val,
  output logic                 spike,
  output logic [TSW-1:0]       timestamp
);

  localparam int PW = 2*DW + 1;
  localparam int SW = DW + FRAC;
  localparam int TW = KW + 2*DW;

  logic signed [DW-1:0] x1_q, x2_q;
  logic [SW-1:0]        sig_q;
  logic [KW-1:0]        k_q;
  logic [RW-1:0]        refr_q;
  logic [RW-1:0]        lock_q;
  logic [TSW-1:0]       ts_q;

  logic signed [PW-1:0] prod_a, prod_b, psi;
  assign prod_a = PW'(x1_q) * PW'(x1_q);
  assign prod_b = PW'(in_sample) * PW'(x2_q);
  assign psi    = prod_a - prod_b;

  logic [DW-1:0] absx;
  assign absx = in_sample[DW-1] ? DW'(-in_sample) : in_sample;

  logic signed [SW:0] diff, sig_nx;
  assign diff   = $signed({1'b0, absx, {FRAC{1'b0}}}) - $signed({1'b0, sig_q});
  assign sig_nx = $signed({1'b0, sig_q}) + (diff >>> SHIFT);

  logic [DW-1:0] sig_int;
  assign sig_int = sig_q[SW-1:FRAC];

  logic [TW-1:0] thr, psi_mag;
  assign thr = {{(TW-KW){1'b0}}, k_q} * {{(TW-DW){1'b0}}, sig_int} * {{(TW-DW){1'b0}}, sig_int};
  assign psi_mag = {{(TW-PW+1){1'b0}}, psi[PW-2:0]};

  logic fire;
  assign fire = in_valid && (lock_q == '0) && !psi[PW-1] && (psi_mag > thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q      <= '0;
      x2_q      <= '0;
      sig_q     <= '0;
      k_q       <= KW'(K_DEF);
      refr_q    <= RW'(REFR_DEF);
      lock_q    <= '0;
      ts_q      <= '0;
      spike     <= 1'b0;
      timestamp <= '0;
    end else begin
      if (cfg_k_we)    k_q    <= cfg_k_val;
      if (cfg_refr_we) refr_q <= cfg_refr_val;
      spike <= fire;
      if (fire) timestamp <= ts_q;
      if (in_valid) begin
        x2_q  <= x1_q;
        x1_q  <= in_sample;
        sig_q <= sig_nx[SW-1:0];
        ts_q  <= ts_q + TSW'(1);
        if (fire)               lock_q <= refr_q;
        else if (lock_q != '0)  lock_q <= lock_q - RW'(1);
      end
    end
  end

  // R2
  neg_energy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> !$past(psi[PW-1]));

  // R3
  sigma_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_q <= SW'((1 << (DW-1)) << FRAC));

  // R5
  spike_from_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> $past(in_valid));

  // R6
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spike |-> $stable(timestamp));

  // R6
  ts_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ts_q == '1) |=> ts_q == '0);

  // R7
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lock_q != '0) |=> !spike);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sig_q) && $stable(ts_q) && $stable(lock_q) && !spike));

endmodule

// File: tb/neo_spike_det_test.sv
module neo_spike_det_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [7:0] in_sample = '0;
  logic cfg_k_we = 1'b0, cfg_refr_we = 1'b0;
  logic [7:0] cfg_k_val = '0, cfg_refr_val = '0;
  logic spike;
  logic [6:0] timestamp;

  always #2 clk = ~clk;

  neo_spike_det uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_k_we(cfg_k_we), .cfg_k_val(cfg_k_val),
    .cfg_refr_we(cfg_refr_we), .cfg_refr_val(cfg_refr_val),
    .spike(spike), .timestamp(timestamp)
  );

  int checks = 0, errors = 0;
  int m_x1, m_x2, m_sig, m_ts, m_lock, m_k, m_rl, m_last_ts;
  int rng = 32'h1234567;
  int fires = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_x1 = 0; m_x2 = 0; m_sig = 0; m_ts = 0; m_lock = 0;
    m_k = 5; m_rl = 50; m_last_ts = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    model_reset();
    check(spike == 1'b0, "R1 spike", spike, 0);
    check(timestamp == 7'd0, "R1 timestamp", timestamp, 0);
    rst_n = 1'b1;
  endtask

  task automatic feed(input int x);
    int psi, m, thr, a;
    bit exp_fire;
    psi = m_x1*m_x1 - x*m_x2;
    m = m_sig >>> 4;
    thr = m_k*m*m;
    exp_fire = (m_lock == 0) && (psi > thr);
    if (exp_fire) begin
      m_last_ts = m_ts;
      m_lock = m_rl;
    end else if (m_lock > 0) m_lock--;
    a = (x < 0) ? -x : x;
    m_sig = m_sig + (((a <<< 4) - m_sig) >>> 4);
    m_x2 = m_x1; m_x1 = x;
    m_ts = (m_ts + 1) % 128;
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 8'(x);
    @(negedge clk);
    in_valid = 1'b0;
    if (exp_fire) fires++;
    // R2 R4 R5 R7: detection decision for this sample
    check(spike == exp_fire, "R4/R5/R7 spike", spike, exp_fire);
    // R6: timestamp of last detection
    check(timestamp == 7'(m_last_ts), "R6 timestamp", timestamp, m_last_ts);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sample = 8'sd99;
    end
    // R9: idle cycles leave no trace; next sample checked against unchanged model
    check(spike == 1'b0, "R9 idle spike", spike, 0);
    check(timestamp == 7'(m_last_ts), "R9 idle timestamp", timestamp, m_last_ts);
  endtask

  task automatic set_cfg(input int k, input int rl);
    @(negedge clk);
    cfg_k_we = 1'b1; cfg_k_val = 8'(k);
    cfg_refr_we = 1'b1; cfg_refr_val = 8'(rl);
    @(negedge clk);
    cfg_k_we = 1'b0; cfg_refr_we = 1'b0;
    m_k = k; m_rl = rl;  // R8
  endtask

  function automatic int next_rand();
    rng = rng * 1103515245 + 12345;
    return (rng >>> 8) & 32'hFFFF;
  endfunction

  task automatic noisy_run(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      int r;
      r = next_rand();
      if (i % period == 0) feed(60 + (r % 60));
      else if (i % period == 1) feed(-128 + (r % 20));
      else if (i % period == 2) feed(127 - (r % 30));
      else feed((r % 9) - 4);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  int vals[7] = '{-128, -64, -1, 0, 1, 63, 127};

  initial begin
    do_reset();
    // R1: defaults k=5, lockout 50 drive the model
    noisy_run(400, 17);
    idle(5);
    noisy_run(100, 23);
    // R2: exhaustive triples with zero threshold, no lockout
    set_cfg(0, 0);
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        for (int c = 0; c < 7; c++) begin
          feed(vals[a]); feed(vals[b]); feed(vals[c]);
        end
    // R7 R8: sweep gain and lockout lengths
    for (int ki = 0; ki < 4; ki++)
      for (int li = 0; li < 4; li++) begin
        int kv[4] = '{1, 5, 20, 255};
        int lv[4] = '{0, 1, 3, 50};
        set_cfg(kv[ki], lv[li]);
        noisy_run(150, 7 + ki + li);
        idle(3);
      end
    // R3: large steady magnitude saturates the noise average near 128
    set_cfg(1, 0);
    for (int i = 0; i < 200; i++) feed((i % 2) ? -128 : 127);
    // R6: wrap of the sample index over several rollovers
    set_cfg(0, 0);
    for (int i = 0; i < 300; i++) feed((i % 3 == 0) ? 50 : 0);
    // R1: reset again after configuration change restores defaults
    do_reset();
    noisy_run(300, 31);
    check(fires > 0, "R4 detections seen", fires, 1);
    done = 1;
    finish_run();
  end
endmodule